// File: doc/BRIEF.md
# Serial Slave Front End for a Quad Digital Potentiometer

This block is the receive side of a two-wire serial slave that sits ahead of the register bank of a four-channel digital potentiometer. It brings the clock and data lines into the system clock domain and finds start and stop conditions. It shifts in the address byte that follows a start and acknowledges only when that byte names this device. It then takes the instruction byte, splits it into an operation code, a register index and a potentiometer index, and hands them downstream. Any further bytes in the same transfer are acknowledged and passed on unchanged.

When a stop closes a transfer whose instruction was the nonvolatile write operation, the block goes busy for a programmable number of clock cycles. While it is busy it refuses to acknowledge even its own address. A master can therefore keep issuing start plus address and read the missing acknowledge as "still writing". A start seen at any point, including in the middle of a byte, drops the current transfer and begins a new address reception.

Top module: `potSerialFront`

## Requirements
- R1: After reset the data output enable `sdaOe`, `busy`, `instrValid` and `dataValid` are all low.
- R2: An address byte is received most significant bit first and is acknowledged only when all eight bits equal {TYPE_ID, strapAddr}, where TYPE_ID defaults to 4'b0101 and fills bits 7..4. On any other value the data line stays released through the ninth clock pulse.
- R3: An acknowledge drives `sdaOe` high from the falling clock edge that ends the eighth bit until the falling edge that ends the ninth pulse, and `sdaOe` is low again within a few system clocks after that edge.
- R4: The byte after an acknowledged address is split as opcode = bits 7..4, regIdx = bits 3..2, potIdx = bits 1..0. The three values are presented with a one-cycle `instrValid` pulse, and the byte is acknowledged.
- R5: Every byte after the instruction byte in the same transfer appears on `dataByte` with a one-cycle `dataValid` pulse and is acknowledged.
- R6: After an address byte that was not acknowledged, later bytes of that transfer give no acknowledge, no `instrValid` and no `dataValid`.
- R7: A stop that ends a transfer whose instruction opcode equals NV_WRITE_OP (default 4'b1100) raises `busy` for exactly BUSY_CYCLES system clocks. A stop after any other opcode leaves `busy` low.
- R8: While `busy` is high, a matching address byte is not acknowledged. Once `busy` has fallen, the same address is acknowledged again.
- R9: A start condition in the middle of a byte aborts that byte and restarts address reception, so that a full matching address sent next is acknowledged and its transfer decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line, asynchronous |
| sdaIn | input | 1 | Serial data line as seen on the wire, asynchronous |
| strapAddr | input | 4 | Strapped device address, compared with address bits 3..0 |
| sdaOe | output | 1 | When high, the pad pulls the data line low (acknowledge) |
| instrValid | output | 1 | One-cycle strobe: opcode, regIdx and potIdx are new |
| opcode | output | 4 | Instruction byte bits 7..4 |
| regIdx | output | 2 | Instruction byte bits 3..2 |
| potIdx | output | 2 | Instruction byte bits 1..0 |
| dataValid | output | 1 | One-cycle strobe: dataByte is new |
| dataByte | output | 8 | Byte received after the instruction byte |
| busy | output | 1 | Internal nonvolatile write period in progress |

## Verification
The bench builds the block with BUSY_CYCLES set to 150 and keeps the default type code, opcode and two-stage synchronizer. With that value the busy window can be measured cycle-exactly each time it occurs, without crowding the run budget. Every one of the 256 address bytes is swept against one strap setting, every strap setting is matched, and all 256 instruction bytes are decoded. The nonvolatile opcode therefore shows up sixteen times, each with its own measured busy window.

// File: rtl/potSerialPkg.sv
package potSerialPkg;

  // Events raised by the datapath for the control
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic byteDone;
  } busEvt_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clrBits;
    logic driveAck;
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_DATA,
    ST_SKIP
  } phase_t;

endpackage

// File: rtl/potSerialDatapath.sv
module potSerialDatapath
  import potSerialPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  ctlStrobe_t           ctl,
  output busEvt_t              evt,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic                 sdaOe
);

  localparam int CNT_W = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_BITS + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic sclRise, sclFall;
  logic [CNT_W-1:0] bitCnt;

  // Synchronizer chains (SYNC_STAGES must be at least 2)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow  = sclSync[SYNC_STAGES-1];
  assign sdaNow  = sdaSync[SYNC_STAGES-1];
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;

  assign evt.startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign evt.stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign evt.byteDone  = sclFall && (bitCnt == LAST_BIT);

  // Bit counter and shifter: 0..7 data bits, 8 = byte in, 9 = ack pulse high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else if (ctl.clrBits) begin
      bitCnt <= '0;
    end else if (sclRise && bitCnt < LAST_BIT) begin
      rxByte <= {rxByte[BYTE_BITS-2:0], sdaNow};
      bitCnt <= bitCnt + 1'b1;
    end else if (sclRise && bitCnt == LAST_BIT) begin
      bitCnt <= ACK_SLOT;
    end else if (sclFall && bitCnt == ACK_SLOT) begin
      bitCnt <= '0;
    end
  end

  // Open-drain acknowledge enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      sdaOe <= 1'b0;
    else if (ctl.clrBits)
      sdaOe <= 1'b0;
    else if (ctl.driveAck)
      sdaOe <= 1'b1;
    else if (sclFall && bitCnt == ACK_SLOT)
      sdaOe <= 1'b0;
  end

  // R3: acknowledge only begins at the end of a byte
  p_ack_at_byte_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(bitCnt) == LAST_BIT);

  // R3: acknowledge released after the ninth pulse ends
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe && sclFall && bitCnt == ACK_SLOT) |=> !sdaOe);

  // R2: bits only shift while the clock is rising inside a byte
  p_shift_on_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt != $past(bitCnt) && bitCnt != '0 && bitCnt != ACK_SLOT) |-> $past(sclRise));

endmodule

// File: rtl/potSerialControl.sv
module potSerialControl
  import potSerialPkg::*;
#(
  parameter logic [3:0] TYPE_ID = 4'b0101,
  parameter logic [3:0] NV_WRITE_OP = 4'b1100,
  parameter int BUSY_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic [7:0] rxByte,
  input  logic [3:0] strapAddr,
  output ctlStrobe_t ctl,
  output logic       instrValid,
  output logic [3:0] opcode,
  output logic [1:0] regIdx,
  output logic [1:0] potIdx,
  output logic       dataValid,
  output logic [7:0] dataByte,
  output logic       busy
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  phase_t st;
  logic nvPend;
  logic addrMatch;
  logic [BUSY_W-1:0] busyCnt;

  assign addrMatch = (rxByte == {TYPE_ID, strapAddr});
  assign busy = (busyCnt != '0);

  assign ctl.clrBits  = evt.startSeen | evt.stopSeen;
  assign ctl.driveAck = evt.byteDone &&
                        ((st == ST_ADDR && addrMatch && !busy) ||
                         st == ST_INSTR || st == ST_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      nvPend     <= 1'b0;
      instrValid <= 1'b0;
      dataValid  <= 1'b0;
      opcode     <= '0;
      regIdx     <= '0;
      potIdx     <= '0;
      dataByte   <= '0;
    end else begin
      instrValid <= 1'b0;
      dataValid  <= 1'b0;
      if (evt.startSeen) begin
        st     <= ST_ADDR;
        nvPend <= 1'b0;
      end else if (evt.stopSeen) begin
        st     <= ST_IDLE;
        nvPend <= 1'b0;
      end else if (evt.byteDone) begin
        unique case (st)
          ST_ADDR: st <= (addrMatch && !busy) ? ST_INSTR : ST_SKIP;
          ST_INSTR: begin
            opcode     <= rxByte[7:4];
            regIdx     <= rxByte[3:2];
            potIdx     <= rxByte[1:0];
            instrValid <= 1'b1;
            nvPend     <= (rxByte[7:4] == NV_WRITE_OP);
            st         <= ST_DATA;
          end
          ST_DATA: begin
            dataByte  <= rxByte;
            dataValid <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // Busy window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      busyCnt <= '0;
    else if (evt.stopSeen && nvPend)
      busyCnt <= BUSY_W'(BUSY_CYCLES);
    else if (busy)
      busyCnt <= busyCnt - BUSY_W'(1);
  end

  // R8: an address ending while busy leads to the skip phase
  p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ADDR && evt.byteDone && busy && !evt.startSeen && !evt.stopSeen)
      |=> st == ST_SKIP);

  // R7: busy counts down by one per cycle
  p_busy_countdown_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(evt.stopSeen && nvPend)) |=> busyCnt == $past(busyCnt) - BUSY_W'(1));

  // R4: instruction strobe lasts one cycle
  p_instr_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |=> !instrValid);

  // R9: a start always restarts address reception
  p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rstN)
    evt.startSeen |=> st == ST_ADDR);

  // R6: nothing is decoded after a refused address
  p_skip_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SKIP) |-> !ctl.driveAck);

endmodule

// File: rtl/potSerialFront.sv
module potSerialFront
  import potSerialPkg::*;
#(
  parameter logic [3:0] TYPE_ID = 4'b0101,
  parameter logic [3:0] NV_WRITE_OP = 4'b1100,
  parameter int BUSY_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [3:0] strapAddr,
  output logic       sdaOe,
  output logic       instrValid,
  output logic [3:0] opcode,
  output logic [1:0] regIdx,
  output logic [1:0] potIdx,
  output logic       dataValid,
  output logic [7:0] dataByte,
  output logic       busy
);

  busEvt_t    evt;
  ctlStrobe_t ctl;
  logic [7:0] rxByte;

  potSerialDatapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .BYTE_BITS(8)
  ) uDatapath (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .ctl(ctl),
    .evt(evt),
    .rxByte(rxByte),
    .sdaOe(sdaOe)
  );

  potSerialControl #(
    .TYPE_ID(TYPE_ID),
    .NV_WRITE_OP(NV_WRITE_OP),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) uControl (
    .clk(clk),
    .rstN(rstN),
    .evt(evt),
    .rxByte(rxByte),
    .strapAddr(strapAddr),
    .ctl(ctl),
    .instrValid(instrValid),
    .opcode(opcode),
    .regIdx(regIdx),
    .potIdx(potIdx),
    .dataValid(dataValid),
    .dataByte(dataByte),
    .busy(busy)
  );

endmodule

// File: tb/potSerialFront_test.sv
`timescale 1ns/1ps
module potSerialFront_test;

  localparam int BUSY = 150;
  localparam int Q = 5;
  localparam logic [3:0] NV_OP = 4'b1100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic [3:0] strapAddr = 4'hA;
  logic sdaOe, instrValid, dataValid, busy;
  logic [3:0] opcode;
  logic [1:0] regIdx, potIdx;
  logic [7:0] dataByte;
  logic sdaLine;

  int checks = 0;
  int errors = 0;
  int instrCnt = 0;
  int dataCnt = 0;
  int busyRun = 0;
  logic [7:0] lastInstr = '0;
  logic [7:0] lastData = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign sdaLine = sdaDrv & ~sdaOe;

  potSerialFront #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .strapAddr(strapAddr), .sdaOe(sdaOe), .instrValid(instrValid),
    .opcode(opcode), .regIdx(regIdx), .potIdx(potIdx),
    .dataValid(dataValid), .dataByte(dataByte), .busy(busy)
  );

  always @(posedge clk) begin
    if (instrValid) begin
      instrCnt <= instrCnt + 1;
      lastInstr <= {opcode, regIdx, potIdx};
    end
    if (dataValid) begin
      dataCnt <= dataCnt + 1;
      lastData <= dataByte;
    end
    if (busy) busyRun <= busyRun + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; waitQ(Q);
    sclDrv = 1'b1; waitQ(Q);
    sdaDrv = 1'b0; waitQ(Q);
    sclDrv = 1'b0; waitQ(Q);
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; waitQ(Q);
    sclDrv = 1'b1; waitQ(Q);
    sdaDrv = 1'b1; waitQ(Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdaDrv = b[7-i]; waitQ(Q);
      sclDrv = 1'b1;   waitQ(Q);
      sclDrv = 1'b0;   waitQ(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked, output bit released);
    sendBits(b, 8);
    sdaDrv = 1'b1; waitQ(Q);
    sclDrv = 1'b1; waitQ(Q);
    acked = (sdaLine == 1'b0);
    sclDrv = 1'b0; waitQ(Q);
    released = !sdaOe;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    waitQ(2);
  endtask

  initial begin
    bit ack, rel;
    int i0, d0, b0;
    logic [7:0] myAddr;

    waitQ(3);
    // R1: reset state
    check(!sdaOe && !busy && !instrValid && !dataValid, "R1 reset outputs",
          {sdaOe, busy, instrValid, dataValid}, 0);
    rstN = 1'b1;
    waitQ(4);
    check(!sdaOe && !busy, "R1 after reset release", {sdaOe, busy}, 0);

    // R2/R3: sweep every address byte against one strap value
    strapAddr = 4'hA;
    for (int a = 0; a < 256; a++) begin
      startCond();
      sendByte(8'(a), ack, rel);
      check(ack == (a == 8'h5A), "R2 address match", ack, (a == 8'h5A));
      check(rel, "R3 release after ninth pulse", sdaOe, 0);
      stopCond();
    end

    // R2: every strap value matched
    for (int s = 0; s < 16; s++) begin
      strapAddr = 4'(s);
      startCond();
      sendByte({4'b0101, 4'(s)}, ack, rel);
      check(ack, "R2 strap match", ack, 1);
      stopCond();
    end
    strapAddr = 4'hA;
    myAddr = 8'h5A;

    // R4/R7: sweep every instruction byte
    for (int v = 0; v < 256; v++) begin
      i0 = instrCnt;
      busyRun = 0;
      startCond();
      sendByte(myAddr, ack, rel);
      sendByte(8'(v), ack, rel);
      check(ack, "R4 instruction acked", ack, 1);
      check(instrCnt == i0 + 1 && lastInstr == 8'(v), "R4 instruction split",
            lastInstr, v);
      check(opcode == 4'(v >> 4) && regIdx == 2'(v >> 2) && potIdx == 2'(v),
            "R4 field positions", {opcode, regIdx, potIdx}, v);
      stopCond();
      waitIdle();
      if (4'(v >> 4) == NV_OP)
        check(busyRun == BUSY, "R7 busy length after nonvolatile write", busyRun, BUSY);
      else
        check(busyRun == 0, "R7 no busy for other opcode", busyRun, 0);
    end

    // R5: data bytes after the instruction
    d0 = dataCnt;
    startCond();
    sendByte(myAddr, ack, rel);
    sendByte(8'h2B, ack, rel);
    sendByte(8'h3C, ack, rel);
    check(ack && dataCnt == d0 + 1 && lastData == 8'h3C, "R5 first data byte", lastData, 8'h3C);
    sendByte(8'hA5, ack, rel);
    check(ack && dataCnt == d0 + 2 && lastData == 8'hA5, "R5 second data byte", lastData, 8'hA5);
    stopCond();

    // R6: refused address, later bytes silent
    i0 = instrCnt; d0 = dataCnt;
    startCond();
    sendByte(8'h5B, ack, rel);
    check(!ack, "R6 wrong address nack", ack, 0);
    sendByte(8'h55, ack, rel);
    check(!ack, "R6 no ack after refusal", ack, 0);
    sendByte(8'h66, ack, rel);
    check(!ack && instrCnt == i0 && dataCnt == d0, "R6 no decode after refusal",
          instrCnt - i0 + dataCnt - d0, 0);
    stopCond();

    // R8: acknowledge polling
    busyRun = 0;
    startCond();
    sendByte(myAddr, ack, rel);
    sendByte({NV_OP, 4'h6}, ack, rel);
    sendByte(8'h11, ack, rel);
    stopCond();
    check(busy, "R7 busy raised after stop", busy, 1);
    startCond();
    sendByte(myAddr, ack, rel);
    check(!ack, "R8 nack while busy", ack, 0);
    stopCond();
    b0 = 0;
    while (busy) begin
      startCond();
      sendByte(myAddr, ack, rel);
      stopCond();
      if (busy && ack) b0++;
    end
    check(b0 == 0, "R8 no ack during busy polling", b0, 0);
    check(busyRun == BUSY, "R7 busy length with polling", busyRun, BUSY);
    startCond();
    sendByte(myAddr, ack, rel);
    check(ack, "R8 ack after busy ends", ack, 1);
    stopCond();

    // R9: start in the middle of a byte
    i0 = instrCnt;
    startCond();
    sendBits(8'hF3, 4);
    startCond();
    sendByte(myAddr, ack, rel);
    check(ack, "R9 address after aborted byte", ack, 1);
    sendByte(8'h9E, ack, rel);
    check(instrCnt == i0 + 1 && lastInstr == 8'h9E, "R9 decode after restart", lastInstr, 8'h9E);
    startCond();
    sendBits(8'h5A, 6);
    startCond();
    sendByte(myAddr, ack, rel);
    check(ack, "R9 restart inside address byte", ack, 1);
    stopCond();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule